// File: doc/BRIEF.md
# Saturating Up/Down Counter Field

This block is a hardware-updated counter register of parameterized width. Hardware moves it through two single-bit request inputs, one to count up and one to count down. Each request carries a step size. The step is either an elaboration-time constant or a value read from an input port on every request. When both requests arrive in the same cycle, the counter moves by the net difference of the two steps.

Each direction can stop at a limit or wrap around. Set to saturate, an upward move that passes the upper limit clamps there, and a downward move that passes the lower limit clamps there. Set to wrap, the value rolls over modulo 2^WIDTH. In both cases a one-cycle pulse marks each crossing of a limit. Two level flags compare the held count against an upper and a lower threshold.

A per-bit gate vector can freeze individual bits of the count. It acts as an enable or as a mask, chosen by a parameter. The reset can be asynchronous or synchronous. A configuration in which both steps are the constant zero stops elaboration with an error.

Top module: `sat_updown_field`

## Requirements
- R1: While `rst_n` is low, `count_o` equals RESET_VAL and `ovf_o` and `unf_o` are low. With ASYNC_RST=1 this takes effect at once. With ASYNC_RST=0 it takes effect at the next rising clock edge.
- R2: A step parameter (INC_STEP, DEC_STEP) of -1 takes the step from its port (`inc_step_i`, `dec_step_i`), zero-extended, on every request. A value of 0 or more uses that constant. The default is 1.
- R3: A cycle with `incr_i` and `decr_i` both low leaves `count_o` unchanged. Neither pulse output is raised after that cycle.
- R4: Updates are registered. The new count appears at the edge that samples the requests. With both requests high, the count moves by the increment step minus the decrement step.
- R5: `ovf_o` is high for exactly the cycle after an edge at which `incr_i` was high and count + inc − dec exceeded the overflow point. The overflow point is INC_SAT when INC_SAT ≥ 0, and 2^WIDTH−1 otherwise.
- R6: INC_SAT = -2 disables upper saturation, so an overflowing result wraps modulo 2^WIDTH. INC_SAT = -1 or INC_SAT ≥ 0 clamps the result to the overflow point.
- R7: `unf_o` is high for exactly the cycle after an edge at which `decr_i` was high and count + inc − dec fell below the underflow point. The underflow point is DEC_SAT when DEC_SAT ≥ 0, and 0 otherwise.
- R8: DEC_SAT = -2 disables lower saturation, so an underflowing result wraps modulo 2^WIDTH. Any other setting clamps the result to the underflow point.
- R9: `ovf_o` and `unf_o` are never high together.
- R10: `thr_hi_o` is high while the count is ≥ the upper threshold and `thr_lo_o` is high while the count is ≤ the lower threshold. For each threshold parameter (INC_THR, DEC_THR), a value ≥ 0 is used directly, -1 means 2^WIDTH−1, and -2 holds the flag low.
- R11: With GATE_IS_MASK=0, bit i of the count updates only when `hw_gate_i[i]`=1. With GATE_IS_MASK=1, bit i is held when `hw_gate_i[i]`=1. The pulses are computed from the ungated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| incr_i | input | 1 | Count-up request |
| decr_i | input | 1 | Count-down request |
| inc_step_i | input | INC_W | Runtime up step, used when INC_STEP = -1 |
| dec_step_i | input | DEC_W | Runtime down step, used when DEC_STEP = -1 |
| hw_gate_i | input | WIDTH | Per-bit enable or mask of the count update |
| count_o | output | WIDTH | Current count |
| ovf_o | output | 1 | One-cycle overflow pulse |
| unf_o | output | 1 | One-cycle underflow pulse |
| thr_hi_o | output | 1 | Count at or above the upper threshold |
| thr_lo_o | output | 1 | Count at or below the lower threshold |

## Verification
The bench builds two instances side by side, and each covers the opposite variant of every option. The first is 6 bits wide and uses an asynchronous reset. It takes a 3-bit runtime up step and a constant down step of 2, clamps at a numeric upper limit of 50, wraps below zero, uses numeric thresholds of 40 and 5, and treats the gate as an enable. The second is 5 bits wide and uses a synchronous reset. It has a constant up step, a 2-bit runtime down step, a wrapping top, a numeric lower clamp of 3, a plain-flag upper threshold, a disabled lower threshold, and a mask-polarity gate. Together they reach clamping and wrapping in both directions, zero-valued runtime steps, net-zero simultaneous requests, and partially frozen counts at the limits.

// File: rtl/cnt_field_pkg.sv
package cnt_field_pkg;

  // Setting codes shared by the saturation, threshold and step parameters
  localparam int CNT_OFF  = -2;  // feature disabled
  localparam int CNT_FLAG = -1;  // enabled with its implied default value
  localparam int CNT_PORT = -1;  // step taken from the runtime port

  typedef struct packed {
    logic ovf;
    logic unf;
  } cnt_evt_t;

endpackage

// File: rtl/cnt_step_src.sv
module cnt_step_src
  import cnt_field_pkg::*;
#(
  parameter int W    = 8,
  parameter int STEP = 1,
  parameter int PW   = 1
) (
  input  logic          req_i,
  input  logic [PW-1:0] port_val_i,
  output logic [W-1:0]  amt_o
);

  generate
    if (STEP == CNT_PORT) begin : g_port
      always_comb begin
        amt_o = '0;
        if (req_i) amt_o = W'(port_val_i);
      end
    end else begin : g_const
      localparam logic [W-1:0] K = W'(STEP);
      logic unused_step_bits;
      assign unused_step_bits = ^port_val_i;
      always_comb begin
        amt_o = '0;
        if (req_i) amt_o = K;
      end
    end
  endgenerate

endmodule

// File: rtl/cnt_next_calc.sv
module cnt_next_calc
  import cnt_field_pkg::*;
#(
  parameter int W         = 8,
  parameter int OVF_PT    = 255,
  parameter int UNF_PT    = 0,
  parameter bit INC_CLAMP = 1'b0,
  parameter bit DEC_CLAMP = 1'b0
) (
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] inc_amt_i,
  input  logic [W-1:0] dec_amt_i,
  input  logic         incr_i,
  input  logic         decr_i,
  output logic [W-1:0] cand_o,
  output cnt_evt_t     evt_o
);

  localparam int EXT_W = W + 2;
  localparam logic signed [EXT_W-1:0] OVF_S = EXT_W'(OVF_PT);
  localparam logic signed [EXT_W-1:0] UNF_S = EXT_W'(UNF_PT);
  localparam logic [W-1:0] OVF_V = W'(OVF_PT);
  localparam logic [W-1:0] UNF_V = W'(UNF_PT);

  // Net move in two guard bits so both crossings are visible
  logic signed [EXT_W-1:0] sum;
  assign sum = $signed({2'b00, q_i}) + $signed({2'b00, inc_amt_i})
             - $signed({2'b00, dec_amt_i});

  always_comb begin
    evt_o.ovf = incr_i && (sum > OVF_S);
    evt_o.unf = decr_i && (sum < UNF_S);
    cand_o    = sum[W-1:0];
    if (evt_o.ovf && INC_CLAMP)      cand_o = OVF_V;
    else if (evt_o.unf && DEC_CLAMP) cand_o = UNF_V;
  end

endmodule

// File: rtl/cnt_bit_gate.sv
module cnt_bit_gate #(
  parameter int W        = 8,
  parameter bit MASK_POL = 1'b0
) (
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] gate_i,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] live_o
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      if (MASK_POL) begin : g_mask
        assign live_o[b] = ~gate_i[b];
      end else begin : g_en
        assign live_o[b] = gate_i[b];
      end
      assign nxt_o[b] = live_o[b] ? cand_i[b] : q_i[b];
    end
  endgenerate

endmodule

// File: rtl/sat_updown_field.sv
module sat_updown_field
  import cnt_field_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter int INC_STEP     = 1,
  parameter int INC_W        = 1,
  parameter int DEC_STEP     = 1,
  parameter int DEC_W        = 1,
  parameter int INC_SAT      = CNT_OFF,
  parameter int DEC_SAT      = CNT_OFF,
  parameter int INC_THR      = CNT_OFF,
  parameter int DEC_THR      = CNT_OFF,
  parameter int RESET_VAL    = 0,
  parameter bit GATE_IS_MASK = 1'b0,
  parameter bit ASYNC_RST    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             incr_i,
  input  logic             decr_i,
  input  logic [INC_W-1:0] inc_step_i,
  input  logic [DEC_W-1:0] dec_step_i,
  input  logic [WIDTH-1:0] hw_gate_i,
  output logic [WIDTH-1:0] count_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             thr_hi_o,
  output logic             thr_lo_o
);

  localparam int MAXV      = (1 << WIDTH) - 1;
  localparam int OVF_PT    = (INC_SAT >= 0) ? INC_SAT : MAXV;
  localparam int UNF_PT    = (DEC_SAT >= 0) ? DEC_SAT : 0;
  localparam bit INC_CLAMP = (INC_SAT != CNT_OFF);
  localparam bit DEC_CLAMP = (DEC_SAT != CNT_OFF);
  localparam int HI_THR    = (INC_THR >= 0) ? INC_THR : MAXV;
  localparam int LO_THR    = (DEC_THR >= 0) ? DEC_THR : MAXV;
  localparam logic [WIDTH-1:0] HI_THR_W = WIDTH'(HI_THR);
  localparam logic [WIDTH-1:0] LO_THR_W = WIDTH'(LO_THR);
  localparam logic [WIDTH-1:0] RST_W    = WIDTH'(RESET_VAL);

  // Elaboration-time configuration checks
  generate
    if (INC_STEP == 0 && DEC_STEP == 0) begin : g_bad_steps
      $error("counter field: both step constants are zero");
    end
    if (INC_W > WIDTH || DEC_W > WIDTH) begin : g_bad_port_w
      $error("counter field: step port wider than the count");
    end
    if (UNF_PT > OVF_PT) begin : g_bad_limits
      $error("counter field: lower limit above upper limit");
    end
  endgenerate

  logic [WIDTH-1:0] q, q_d;
  logic             ovf_q, unf_q;
  logic [WIDTH-1:0] inc_amt, dec_amt, cand, live;
  cnt_evt_t         evt;
  logic             upd_en;

  cnt_step_src #(.W(WIDTH), .STEP(INC_STEP), .PW(INC_W)) u_inc_step (
    .req_i(incr_i), .port_val_i(inc_step_i), .amt_o(inc_amt)
  );

  cnt_step_src #(.W(WIDTH), .STEP(DEC_STEP), .PW(DEC_W)) u_dec_step (
    .req_i(decr_i), .port_val_i(dec_step_i), .amt_o(dec_amt)
  );

  cnt_next_calc #(
    .W(WIDTH), .OVF_PT(OVF_PT), .UNF_PT(UNF_PT),
    .INC_CLAMP(INC_CLAMP), .DEC_CLAMP(DEC_CLAMP)
  ) u_calc (
    .q_i(q), .inc_amt_i(inc_amt), .dec_amt_i(dec_amt),
    .incr_i(incr_i), .decr_i(decr_i), .cand_o(cand), .evt_o(evt)
  );

  cnt_bit_gate #(.W(WIDTH), .MASK_POL(GATE_IS_MASK)) u_gate (
    .q_i(q), .cand_i(cand), .gate_i(hw_gate_i), .nxt_o(q_d), .live_o(live)
  );

  assign upd_en = incr_i | decr_i;

  // State registers: the count is clock-enabled by a request, the pulses are not
  generate
    if (ASYNC_RST) begin : g_arst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q     <= RST_W;
          ovf_q <= 1'b0;
          unf_q <= 1'b0;
        end else begin
          if (upd_en) q <= q_d;
          ovf_q <= evt.ovf;
          unf_q <= evt.unf;
        end
      end
    end else begin : g_srst
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q     <= RST_W;
          ovf_q <= 1'b0;
          unf_q <= 1'b0;
        end else begin
          if (upd_en) q <= q_d;
          ovf_q <= evt.ovf;
          unf_q <= evt.unf;
        end
      end
    end
  endgenerate

  assign count_o = q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

  generate
    if (INC_THR == CNT_OFF) begin : g_hi_off
      assign thr_hi_o = 1'b0;
    end else begin : g_hi_on
      assign thr_hi_o = (q >= HI_THR_W);
    end
    if (DEC_THR == CNT_OFF) begin : g_lo_off
      assign thr_lo_o = 1'b0;
    end else begin : g_lo_on
      assign thr_lo_o = (q <= LO_THR_W);
    end
  endgenerate

  // R3: no request, no movement and no pulse
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!incr_i && !decr_i) |=> ($stable(q) && !ovf_q && !unf_q));

  // R5: an overflow pulse needs an up request one edge earlier
  a_r5_ovf_needs_incr: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(incr_i));

  // R7: an underflow pulse needs a down request one edge earlier
  a_r7_unf_needs_decr: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> $past(decr_i));

  // R9: the two pulses are exclusive
  a_r9_no_dual_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_q && unf_q));

  // R11: a frozen bit keeps its value across the edge
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_hold_chk
      a_r11_frozen_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !live[b] |=> (q[b] == $past(q[b])));
    end
  endgenerate

endmodule

// File: tb/tb_sat_updown_field.sv
`timescale 1ns/1ps
module tb_sat_updown_field;
  import cnt_field_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // Instance A: 6 bits, runtime up step, clamp at 50, wrap below 0
  logic       a_incr, a_decr;
  logic [2:0] a_istep;
  logic [0:0] a_dstep;
  logic [5:0] a_gate, a_cnt;
  logic       a_ovf, a_unf, a_hi, a_lo;

  // Instance B: 5 bits, runtime down step, wrap at top, clamp at 3
  logic       b_incr, b_decr;
  logic [0:0] b_istep;
  logic [1:0] b_dstep;
  logic [4:0] b_gate, b_cnt;
  logic       b_ovf, b_unf, b_hi, b_lo;

  sat_updown_field #(
    .WIDTH(6), .INC_STEP(CNT_PORT), .INC_W(3), .DEC_STEP(2), .DEC_W(1),
    .INC_SAT(50), .DEC_SAT(CNT_OFF), .INC_THR(40), .DEC_THR(5),
    .RESET_VAL(10), .GATE_IS_MASK(1'b0), .ASYNC_RST(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .incr_i(a_incr), .decr_i(a_decr),
    .inc_step_i(a_istep), .dec_step_i(a_dstep), .hw_gate_i(a_gate),
    .count_o(a_cnt), .ovf_o(a_ovf), .unf_o(a_unf), .thr_hi_o(a_hi), .thr_lo_o(a_lo)
  );

  sat_updown_field #(
    .WIDTH(5), .INC_STEP(1), .INC_W(1), .DEC_STEP(CNT_PORT), .DEC_W(2),
    .INC_SAT(CNT_OFF), .DEC_SAT(3), .INC_THR(CNT_FLAG), .DEC_THR(CNT_OFF),
    .RESET_VAL(4), .GATE_IS_MASK(1'b1), .ASYNC_RST(1'b0)
  ) dut_b (
    .clk(clk), .rst_n(rst_n), .incr_i(b_incr), .decr_i(b_decr),
    .inc_step_i(b_istep), .dec_step_i(b_dstep), .hw_gate_i(b_gate),
    .count_o(b_cnt), .ovf_o(b_ovf), .unf_o(b_unf), .thr_hi_o(b_hi), .thr_lo_o(b_lo)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  int    qa, qb;
  bit    ea_ovf, ea_unf, eb_ovf, eb_unf;
  string ta, tb;

  task automatic cmp(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference for instance A
  task automatic model_a();
    int inc, dec, ext, cand;
    inc = a_incr ? int'(a_istep) : 0;
    dec = a_decr ? 2 : 0;
    ext = qa + inc - dec;
    ea_ovf = a_incr && (ext > 50);
    ea_unf = a_decr && (ext < 0);
    cand = ea_ovf ? 50 : (ext & 63);
    if (ea_ovf)                   ta = "R6";
    else if (ea_unf)              ta = "R8";
    else if (a_gate != 6'h3F)     ta = "R11";
    else if (a_incr && a_decr)    ta = "R4";
    else if (a_incr || a_decr)    ta = "R2";
    else                          ta = "R3";
    if (a_incr || a_decr)
      qa = ((cand & int'(a_gate)) | (qa & ~int'(a_gate))) & 63;
  endtask

  // Behavioural reference for instance B (gate is a mask)
  task automatic model_b();
    int inc, dec, ext, cand;
    inc = b_incr ? 1 : 0;
    dec = b_decr ? int'(b_dstep) : 0;
    ext = qb + inc - dec;
    eb_ovf = b_incr && (ext > 31);
    eb_unf = b_decr && (ext < 3);
    cand = eb_unf ? 3 : (ext & 31);
    if (eb_ovf)                   tb = "R6";
    else if (eb_unf)              tb = "R8";
    else if (b_gate != 5'h00)     tb = "R11";
    else if (b_incr && b_decr)    tb = "R4";
    else if (b_incr || b_decr)    tb = "R2";
    else                          tb = "R3";
    if (b_incr || b_decr)
      qb = ((cand & ~int'(b_gate)) | (qb & int'(b_gate))) & 31;
  endtask

  task automatic check_all();
    cmp({ta, " count A"}, int'(a_cnt), qa);
    cmp("R5 ovf A", int'(a_ovf), int'(ea_ovf));
    cmp("R7 unf A", int'(a_unf), int'(ea_unf));
    cmp("R9 dual A", int'(a_ovf && a_unf), 0);
    cmp("R10 hi A", int'(a_hi), int'(qa >= 40));
    cmp("R10 lo A", int'(a_lo), int'(qa <= 5));
    cmp({tb, " count B"}, int'(b_cnt), qb);
    cmp("R5 ovf B", int'(b_ovf), int'(eb_ovf));
    cmp("R7 unf B", int'(b_unf), int'(eb_unf));
    cmp("R9 dual B", int'(b_ovf && b_unf), 0);
    cmp("R10 hi B", int'(b_hi), int'(qb >= 31));
    cmp("R10 lo B", int'(b_lo), 0);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_a();
    model_b();
    @(negedge clk);
    check_all();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    a_incr = 0; a_decr = 0; a_istep = 0; a_dstep = 0; a_gate = 6'h3F;
    b_incr = 0; b_decr = 0; b_istep = 0; b_dstep = 0; b_gate = 5'h00;
    qa = 10; qb = 4;
    ea_ovf = 0; ea_unf = 0; eb_ovf = 0; eb_unf = 0;
    ta = "R3"; tb = "R3";
    repeat (3) @(negedge clk);
    // R1: reset state of both variants
    cmp("R1 reset A", int'(a_cnt), 10);
    cmp("R1 reset B", int'(b_cnt), 4);
    cmp("R1 pulses", int'(a_ovf | a_unf | b_ovf | b_unf), 0);
    rst_n = 1'b1;

    // R3: idle cycles
    repeat (2) cycle();

    // Count up: A by 7 to its clamp, B by 1 through its wrap
    a_incr = 1; a_istep = 3'd7; b_incr = 1;
    repeat (32) cycle();
    a_istep = 3'd0;  // zero runtime step
    repeat (2) cycle();
    a_incr = 0; b_incr = 0;

    // Count down: A wraps below zero, B clamps at 3
    a_decr = 1; b_decr = 1; b_dstep = 2'd2;
    repeat (30) cycle();
    b_dstep = 2'd0;
    repeat (2) cycle();
    a_decr = 0; b_decr = 0;

    // Simultaneous requests with every step value
    for (int i = 0; i < 16; i++) begin
      a_incr = 1; a_decr = 1; a_istep = 3'(i);
      b_incr = 1; b_decr = 1; b_dstep = 2'(i);
      cycle();
    end
    a_incr = 0; a_decr = 0; b_incr = 0; b_decr = 0;

    // Gated updates
    for (int i = 0; i < 24; i++) begin
      a_gate = 6'($urandom); b_gate = 5'($urandom);
      a_incr = 1; a_istep = 3'($urandom); b_decr = i[0]; b_incr = ~i[0];
      b_dstep = 2'($urandom);
      cycle();
    end
    a_gate = 6'h3F; b_gate = 5'h00;

    // Random traffic
    for (int i = 0; i < 500; i++) begin
      a_incr = 1'($urandom); a_decr = 1'($urandom); a_istep = 3'($urandom);
      b_incr = 1'($urandom); b_decr = 1'($urandom); b_dstep = 2'($urandom);
      a_gate = ($urandom % 4 == 0) ? 6'($urandom) : 6'h3F;
      b_gate = ($urandom % 4 == 0) ? 5'($urandom) : 5'h00;
      cycle();
    end
    a_incr = 0; a_decr = 0; b_incr = 0; b_decr = 0;
    repeat (2) cycle();
    summary();
  end

endmodule